// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Controller

This block is the digital half of a three-channel analog comparator unit. It receives each comparator's output as a digital bit that has already been synchronised to the clock. Each channel can be switched on or off. A channel that is off reads as low and cannot cause an event. The block keeps a snapshot of the enabled outputs. Whenever a live output differs from that snapshot, the channel's event flag is set. The snapshot is taken again whenever software reads or writes the control/status register.

Software reaches three registers through a single-cycle read/write port. The first is the control/status register, which holds the live outputs and the channel enables. The second is the event-flag register. The third is the interrupt-enable register, which holds per-channel enables, a peripheral enable and a global enable. One registered request line combines the flags with all of these enables. A mismatch is not cleared by clearing its flag. Software must first touch the control/status register, and only then will a flag clear stay clear.

Top module: `cmp_change_irq`

## Requirements
- R1: After reset, the snapshot, the flags, the channel enables and every interrupt enable are 0, `irq` is 0, and all three registers read 0.
- R2: Address 0 (control/status) reads the live enabled outputs in bits 7:5 and the channel enables in bits 2:0. Bits 4:3 read 0. Writing address 0 loads bits 2:0 into the channel enables, and data in bits 7:5 has no effect.
- R3: A channel whose enable is 0 reads 0 in bits 7:5, so a change on its input sets no flag.
- R4: When an enabled live output differs from its snapshot bit in a cycle with no control/status access, that channel's flag (address 1, bit i) reads 1 after the next clock edge.
- R5: The mismatch persists. A flag cleared while its mismatch remains is set again, until the control/status register is accessed.
- R6: Any read or write of address 0 recaptures the live outputs into the snapshot, which ends every mismatch.
- R7: If an output changes in the same cycle as a control/status access, the recapture wins and that change sets no flag.
- R8: Writing address 1 loads bits 2:0 into the flags. A 0 clears a flag, and a 1 sets it as a software-raised event.
- R9: If a flag write that clears a bit and a mismatch on the same channel fall in one cycle, the flag stays 1.
- R10: `irq` is registered. It becomes 1 one clock after a cycle in which some flag and its channel interrupt enable (address 2, bits 2:0), the peripheral enable (bit 6) and the global enable (bit 7) are all 1. Otherwise it becomes 0.
- R11: Flags are set by mismatches even while every interrupt enable is 0. Only `irq` is held low.
- R12: Writing address 0 to turn on a channel whose input is high captures the old masked value. This gives a mismatch, and the flag is set one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 3 | Synchronised comparator outputs |
| regAddr | input | 2 | Register address: 0 control/status, 1 flags, 2 interrupt enables |
| regRd | input | 1 | Read strobe; only its effect on the snapshot matters |
| regWr | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `cmpIn` is already synchronous to `clk`, so it changes only between edges. They also assume that at most one register is addressed per cycle, so a flag write can never coincide with a control/status access. The stimulus drives every input on the falling edge and uses one address per cycle. It includes cases where a read and an output change land in the same cycle, and cases where a clearing write meets a live mismatch.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_FLAGS = 2'd1;
  localparam logic [1:0] ADDR_IE    = 2'd2;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic ctrlAccess; // any read or write of the control/status register
    logic ctrlWrite;
    logic flagWrite;
    logic ieWrite;
  } regStrobe_t;

endpackage

// File: rtl/cmpirq_ctrl.sv
module cmpirq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [NUM_CH-1:0] liveOut,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] ieMask,
  input  logic              periphEn,
  input  logic              globalEn,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int OUT_LSB = DATA_W - NUM_CH;

  always_comb begin
    strobe.ctrlAccess = (regAddr == ADDR_CTRL) && (regRd || regWr);
    strobe.ctrlWrite  = (regAddr == ADDR_CTRL) && regWr;
    strobe.flagWrite  = (regAddr == ADDR_FLAGS) && regWr;
    strobe.ieWrite    = (regAddr == ADDR_IE) && regWr;
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        rdData[DATA_W-1:OUT_LSB] = liveOut;
        rdData[NUM_CH-1:0]       = chanEn;
      end
      ADDR_FLAGS: rdData[NUM_CH-1:0] = flags;
      ADDR_IE: begin
        rdData[DATA_W-1]   = globalEn;
        rdData[DATA_W-2]   = periphEn;
        rdData[NUM_CH-1:0] = ieMask;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/cmpirq_datapath.sv
module cmpirq_datapath
  import cmpirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmpIn,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CH-1:0] liveOut,
  output logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] ieMask,
  output logic              periphEn,
  output logic              globalEn,
  output logic              irq
);

  logic [NUM_CH-1:0] chanEnQ, snapQ, flagQ, ieQ, mismatch, flagD;
  logic              periphEnQ, globalEnQ, irqQ;
  logic              unusedWr;

  assign unusedWr = ^wrData;
  assign liveOut  = cmpIn & chanEnQ;
  assign mismatch = liveOut ^ snapQ;

  // Per-channel flag next state: the mismatch set wins over a software write.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
    logic setEvt, baseVal;
    assign setEvt    = mismatch[ch] & ~strobe.ctrlAccess;
    assign baseVal   = strobe.flagWrite ? wrData[ch] : flagQ[ch];
    assign flagD[ch] = baseVal | setEvt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chanEnQ   <= '0;
      snapQ     <= '0;
      flagQ     <= '0;
      ieQ       <= '0;
      periphEnQ <= 1'b0;
      globalEnQ <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      flagQ <= flagD;
      if (strobe.ctrlAccess) snapQ   <= liveOut;
      if (strobe.ctrlWrite)  chanEnQ <= wrData[NUM_CH-1:0];
      if (strobe.ieWrite) begin
        ieQ       <= wrData[NUM_CH-1:0];
        periphEnQ <= wrData[DATA_W-2];
        globalEnQ <= wrData[DATA_W-1];
      end
      irqQ <= (|(flagQ & ieQ)) & periphEnQ & globalEnQ;
    end
  end

  assign chanEn   = chanEnQ;
  assign flags    = flagQ;
  assign ieMask   = ieQ;
  assign periphEn = periphEnQ;
  assign globalEn = globalEnQ;
  assign irq      = irqQ;

  assert_snap_recapture_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.ctrlAccess |=> (snapQ == $past(liveOut)));

  assert_flag_on_mismatch_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe.ctrlAccess && mismatch != '0) |=> ((flagQ & $past(mismatch)) == $past(mismatch)));

  assert_mismatch_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.flagWrite && mismatch != '0) |=> ((flagQ & $past(mismatch)) == $past(mismatch)));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(globalEnQ) && $past(periphEnQ) && ($past(flagQ & ieQ) != '0)));

  assert_quiet_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!strobe.flagWrite && mismatch == '0) |=> (flagQ == $past(flagQ)));

endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
  import cmpirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmpIn,
  input  logic [1:0]        regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);

  regStrobe_t        strobe;
  logic [NUM_CH-1:0] liveOut, chanEn, flags, ieMask;
  logic              periphEn, globalEn;

  cmpirq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .liveOut (liveOut),
    .chanEn  (chanEn),
    .flags   (flags),
    .ieMask  (ieMask),
    .periphEn(periphEn),
    .globalEn(globalEn),
    .strobe  (strobe),
    .rdData  (regRdData)
  );

  cmpirq_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmpIn   (cmpIn),
    .strobe  (strobe),
    .wrData  (regWrData),
    .liveOut (liveOut),
    .chanEn  (chanEn),
    .flags   (flags),
    .ieMask  (ieMask),
    .periphEn(periphEn),
    .globalEn(globalEn),
    .irq     (irq)
  );

endmodule

// File: tb/sim_cmp_change_irq.sv
module sim_cmp_change_irq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmpIn = '0;
  logic [1:0] regAddr = '0;
  logic       regRd = 1'b0, regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cmp_change_irq u0 (.clk(clk), .rst(rst), .cmpIn(cmpIn), .regAddr(regAddr),
    .regRd(regRd), .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq));

  // Behavioural reference model
  logic [2:0] mEn = '0, mSnap = '0, mFlag = '0, mIe = '0;
  logic       mPe = 0, mGe = 0, mIrq = 0;

  function automatic logic [7:0] expRead();
    logic [2:0] eff;
    eff = cmpIn & mEn;
    case (regAddr)
      2'd0: return {eff, 2'b00, mEn};
      2'd1: return {5'b0, mFlag};
      2'd2: return {mGe, mPe, 3'b0, mIe};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [2:0] eff, f;
    logic acc;
    if (rst) begin
      mEn = 0; mSnap = 0; mFlag = 0; mIe = 0; mPe = 0; mGe = 0; mIrq = 0;
    end else begin
      eff = cmpIn & mEn;
      acc = (regAddr == 2'd0) && (regRd || regWr);
      mIrq = ((mFlag & mIe) != 0) && mPe && mGe;
      f = (regWr && regAddr == 2'd1) ? regWrData[2:0] : mFlag;
      if (!acc) f = f | (eff ^ mSnap);
      mFlag = f;
      if (acc) mSnap = eff;
      if (regWr && regAddr == 2'd0) mEn = regWrData[2:0];
      if (regWr && regAddr == 2'd2) begin
        mIe = regWrData[2:0]; mPe = regWrData[6]; mGe = regWrData[7];
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model every clock, after outputs settle.
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      check("R2/R4/R8 model read", regRdData, expRead());
      check("R10 model irq", {7'b0, irq}, {7'b0, mIrq});
    end
  end

  // One bus cycle: drive at falling edge, settle after rising edge.
  task automatic cyc(logic [1:0] a, logic rd, logic wr, logic [7:0] d, logic [2:0] c);
    @(negedge clk);
    regAddr = a; regRd = rd; regWr = wr; regWrData = d; cmpIn = c;
    @(posedge clk); #3;
  endtask

  task automatic idle(logic [1:0] a, logic [2:0] c);
    cyc(a, 0, 0, 8'h00, c);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    idle(2'd0, 3'b000); check("R1 ctrl", regRdData, 8'h00);
    idle(2'd1, 3'b000); check("R1 flags", regRdData, 8'h00);
    idle(2'd2, 3'b000); check("R1 ie", regRdData, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    // R2: write with upper bits set; enable ch1, ch2 only
    cyc(2'd0, 0, 1, 8'hE6, 3'b000);
    idle(2'd0, 3'b000); check("R2 status bits ignored", regRdData, 8'h06);
    // R3: input on disabled ch0 toggles
    idle(2'd1, 3'b001); idle(2'd1, 3'b001);
    check("R3 disabled no flag", regRdData, 8'h00);
    idle(2'd0, 3'b001); check("R3 disabled reads 0", regRdData, 8'h06);
    // R12: enabling ch0 with input high
    cyc(2'd0, 0, 1, 8'h07, 3'b001);
    idle(2'd1, 3'b001); check("R12 mode change flag", regRdData, 8'h01);
    // R9/R5: clear while mismatch persists
    cyc(2'd1, 0, 1, 8'h00, 3'b001);
    idle(2'd1, 3'b001); check("R9 clear loses to mismatch", regRdData, 8'h01);
    idle(2'd1, 3'b001); check("R5 mismatch persists", regRdData, 8'h01);
    // R6: read of ctrl recaptures, then clear sticks
    cyc(2'd0, 1, 0, 8'h00, 3'b001);
    cyc(2'd1, 0, 1, 8'h00, 3'b001);
    idle(2'd1, 3'b001); check("R6 cleared after access", regRdData, 8'h00);
    // R4: ch1 change flags one edge later
    idle(2'd1, 3'b011); check("R4 ch1 flag", regRdData, 8'h02);
    // R7: ch2 change in same cycle as ctrl read
    cyc(2'd0, 1, 0, 8'h00, 3'b111);
    idle(2'd1, 3'b111); check("R7 lost flag", regRdData, 8'h02);
    // R11: flags set with enables off, irq low
    check("R11 irq low", {7'b0, irq}, 8'h00);
    // R10: enable ch1 + peripheral + global
    cyc(2'd2, 0, 1, 8'hC2, 3'b111);
    check("R10 irq not yet", {7'b0, irq}, 8'h00);
    idle(2'd2, 3'b111); check("R10 irq asserted", {7'b0, irq}, 8'h01);
    cyc(2'd2, 0, 1, 8'h42, 3'b111);
    idle(2'd2, 3'b111); check("R10 global off", {7'b0, irq}, 8'h00);
    // R8: software set of ch2
    cyc(2'd1, 0, 1, 8'h06, 3'b111);
    idle(2'd1, 3'b111); check("R8 software set", regRdData, 8'h06);
    cyc(2'd1, 0, 1, 8'h00, 3'b111);
    idle(2'd1, 3'b111); check("R8 clear", regRdData, 8'h00);
    // R10 with peripheral off only
    cyc(2'd2, 0, 1, 8'h84, 3'b111);
    cyc(2'd1, 0, 1, 8'h04, 3'b111);
    idle(2'd1, 3'b111); idle(2'd1, 3'b111);
    check("R10 peripheral off", {7'b0, irq}, 8'h00);
    // varied pattern against model
    for (int i = 0; i < 40; i++) begin
      cyc(2'(i % 3), (i % 5) == 0, (i % 7) == 3, 8'(i * 37), 3'(i * 5 + i / 3));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule